// File: doc/BRIEF.md
# Outbound Command Staging Unit

This block sits on the crate-controller side of a bridge to a network of remote instruments. The controller composes a write command for one remote device through a small set of bus registers. It loads a destination word that holds the node address and the service access point of the device, and a function word. It then adds one or more segments. A segment starts with a write to the address pointer register, which places a tagged delimiter entry carrying the new pointer value into the outbound buffer. Plain 16-bit data writes follow, and each one becomes an untagged buffer entry.

A read of the execute register closes the command. The block updates its error status and offers the buffered entries, in write order, to a downstream packet builder over a valid/ready stream. The destination and function stay visible on side outputs. The block also pulses an invalidate strobe with the destination, so that the cached data of that device is marked stale until fresh data for it arrives. Every bus read carries the current error status in bits 23:16.

Top module: `cmd_stager`

## Requirements
- R1: After reset the destination, function and pointer registers read 0, the error status reads 0x00, and `out_valid` and `inval` are low.
- R2: Reads with `bus_sel` 0, 1 and 2 return the destination, function and pointer registers in bits 15:0. Each of these registers changes only through an accepted write to its own select, or through reset.
- R3: Every bus read returns the error status in bits 23:16, as it stood before that read's own effect. Codes: 0x00 ok, 0x01 overflow, 0x02 busy, 0x03 empty execute.
- R4: An accepted write with `bus_sel`=2 appends an entry with tag 1 and the written pointer value. An accepted write with `bus_sel`=3 appends an entry with tag 0 and the written data word.
- R5: The stream presents the entries in the order they were appended, and `out_last` is high on the final entry only.
- R6: A read with `bus_sel`=4 while idle and with a non-empty buffer raises `out_valid` on the next cycle. It sets the status to 0x01 if an overflow occurred since the previous launch, and to 0x00 otherwise.
- R7: A launch raises `inval` for exactly the one cycle after the execute read, with `inval_dest` equal to the destination register.
- R8: Once DEPTH entries are held, further pointer or data writes append nothing and set the status to 0x01 on the next cycle. The pointer register itself still updates.
- R9: While a command drains, any bus write and any execute read is dropped and sets the status to 0x02. No register, buffer entry or invalidate changes.
- R10: An execute read with an empty buffer sets the status to 0x03. It launches nothing and pulses no `inval`.
- R11: While `out_valid` is high and `out_ready` is low, the stream outputs hold. After the last entry is accepted, `out_valid` is low on the next cycle and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per access |
| bus_rd | input | 1 | Bus read strobe, one cycle per access |
| bus_sel | input | 3 | Register select: 0 dest, 1 func, 2 pointer, 3 data, 4 execute |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 24 | Read data: status in 23:16, register in 15:0 |
| out_valid | output | 1 | Stream entry valid |
| out_ready | input | 1 | Stream entry accepted |
| out_tag | output | 1 | 1 = pointer delimiter, 0 = data word |
| out_word | output | 16 | Entry value |
| out_last | output | 1 | Final entry of the command |
| cmd_dest | output | 16 | Destination of the command |
| cmd_func | output | 16 | Function of the command |
| inval | output | 1 | Invalidate strobe for the target device cache |
| inval_dest | output | 16 | Device whose cache is invalidated |

## Verification
The read data is combinational, so the bench samples it in the same cycle the read strobe is driven. That sample shows the status as it stood before the read. Register and status changes from a write are due one edge later, so the bench checks them on a later read. `inval` and the first `out_valid` are due in the cycle right after the execute edge, so the bench looks at them at the falling edge that follows it. During the drain, the bench checks every entry at a falling edge before the edge that accepts it, under several ready patterns, and confirms at the next falling edge that `out_valid` has dropped.

// File: rtl/cmd_stager.sv
`timescale 1ns/1ps
module cmd_stager #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 16,
  parameter int ERR_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [2:0]              bus_sel,
  input  logic [WORD_W-1:0]       bus_wdata,
  output logic [ERR_W+WORD_W-1:0] bus_rdata,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic                    out_tag,
  output logic [WORD_W-1:0]       out_word,
  output logic                    out_last,
  output logic [WORD_W-1:0]       cmd_dest,
  output logic [WORD_W-1:0]       cmd_func,
  output logic                    inval,
  output logic [WORD_W-1:0]       inval_dest
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int ENT_W = WORD_W + 1;
  localparam logic [2:0] SEL_DEST = 3'd0, SEL_FUNC = 3'd1, SEL_PTR = 3'd2,
                         SEL_DATA = 3'd3, SEL_EXEC = 3'd4;
  localparam logic [ERR_W-1:0] ST_OK = 'h00, ST_OVF = 'h01, ST_BUSY = 'h02, ST_EMPTY = 'h03;

  logic [WORD_W-1:0] dest_q, func_q, ptr_q;
  logic [ERR_W-1:0]  err_q;
  logic [ENT_W-1:0]  ent_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  rd_q;
  logic              busy_q, ovf_q, inval_q;
  logic [WORD_W-1:0] low_rd;

  wire wr_ok  = bus_wr && !busy_q;
  wire push   = wr_ok && (bus_sel == SEL_PTR || bus_sel == SEL_DATA);
  wire full   = cnt_q == CNT_W'(DEPTH);
  wire exec   = bus_rd && bus_sel == SEL_EXEC;
  wire launch = exec && !busy_q && cnt_q != '0;
  wire pop    = busy_q && out_ready;
  wire last   = CNT_W'(rd_q) + CNT_W'(1) == cnt_q;

  always_ff @(posedge clk) begin
    if (push && !full) ent_q[cnt_q[IDX_W-1:0]] <= {bus_sel == SEL_PTR, bus_wdata};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dest_q <= '0; func_q <= '0; ptr_q <= '0; err_q <= ST_OK;
      cnt_q <= '0; rd_q <= '0; busy_q <= 1'b0; ovf_q <= 1'b0; inval_q <= 1'b0;
    end else begin
      inval_q <= launch;
      if (bus_wr && busy_q) err_q <= ST_BUSY;
      if (wr_ok) begin
        case (bus_sel)
          SEL_DEST: dest_q <= bus_wdata;
          SEL_FUNC: func_q <= bus_wdata;
          SEL_PTR:  ptr_q  <= bus_wdata;
          default: ;
        endcase
      end
      if (push) begin
        if (full) begin
          ovf_q <= 1'b1;
          err_q <= ST_OVF;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
      if (exec) begin
        if (busy_q) err_q <= ST_BUSY;
        else if (cnt_q == '0) err_q <= ST_EMPTY;
        else begin
          busy_q <= 1'b1;
          err_q  <= ovf_q ? ST_OVF : ST_OK;
          ovf_q  <= 1'b0;
        end
      end
      if (pop) begin
        if (last) begin
          busy_q <= 1'b0;
          rd_q   <= '0;
          cnt_q  <= '0;
        end else begin
          rd_q <= rd_q + IDX_W'(1);
        end
      end
    end
  end

  always_comb begin
    case (bus_sel)
      SEL_DEST: low_rd = dest_q;
      SEL_FUNC: low_rd = func_q;
      SEL_PTR:  low_rd = ptr_q;
      default:  low_rd = '0;
    endcase
  end

  assign bus_rdata  = {err_q, low_rd};
  assign out_valid  = busy_q;
  assign out_tag    = ent_q[rd_q][WORD_W];
  assign out_word   = ent_q[rd_q][WORD_W-1:0];
  assign out_last   = busy_q && last;
  assign cmd_dest   = dest_q;
  assign cmd_func   = func_q;
  assign inval      = inval_q;
  assign inval_dest = dest_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R8
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_tag) && $stable(out_word)); // R11
  AST_DRAIN_END: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid); // R11
  AST_INVAL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    inval |=> !inval); // R7
  AST_INVAL_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    inval |-> out_valid && $rose(out_valid)); // R6
  AST_DEST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_sel == SEL_DEST) |=> $stable(cmd_dest)); // R2
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && bus_wr |=> $stable(cmd_func) && $stable(cmd_dest)); // R9
endmodule

// File: tb/sim_cmd_stager.sv
`timescale 1ns/1ps
module sim_cmd_stager;
  localparam int DEPTH = 8;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0, out_ready = 0;
  logic [2:0] bus_sel = 0;
  logic [15:0] bus_wdata = 0;
  logic [23:0] bus_rdata;
  logic out_valid, out_tag, out_last, inval;
  logic [15:0] out_word, cmd_dest, cmd_func, inval_dest;
  int total = 0, bad = 0;
  logic        exp_tag  [32];
  logic [15:0] exp_word [32];
  int n_exp;

  always #5 clk = ~clk;

  cmd_stager #(.DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%h exp=%h", req, act, exp); end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); bus_sel = s; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [23:0] v);
    @(negedge clk); bus_sel = s; bus_rd = 1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic drain(input int n, input int sm);
    int i = 0, cyc = 0;
    while (i < n && cyc < 400) begin
      @(negedge clk);
      out_ready = (cyc % sm) == 0;
      #1;
      chk(out_valid === 1'b1, "R5 valid", {31'd0, out_valid}, 1);
      chk(out_tag === exp_tag[i] && out_word === exp_word[i], "R4/R5 entry", {15'd0, out_tag, out_word}, {15'd0, exp_tag[i], exp_word[i]});
      chk(out_last === (i == n - 1), "R5 last", {31'd0, out_last}, {31'd0, i == n - 1});
      if (out_ready) i++;
      cyc++;
    end
    @(negedge clk); out_ready = 0;
    chk(out_valid === 1'b0, "R11 empty", {31'd0, out_valid}, 0);
  endtask

  task automatic exec_ok(input logic [15:0] dest, input logic [7:0] exp_err);
    logic [23:0] v;
    rd(3'd4, v);
    chk(inval === 1'b1 && inval_dest === dest, "R7 inval", {15'd0, inval, inval_dest}, {15'd0, 1'b1, dest});
    chk(out_valid === 1'b1, "R6 launch", {31'd0, out_valid}, 1);
    @(negedge clk);
    chk(inval === 1'b0, "R7 single", {31'd0, inval}, 0);
    rd(3'd0, v);
    chk(v[23:16] === exp_err, "R6 status", {8'd0, v}, {8'd0, exp_err, dest});
    chk(v[15:0] === dest, "R2 dest", {16'd0, v[15:0]}, {16'd0, dest});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=hang exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] v;
    logic [15:0] last_ptr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 3; s++) begin
      rd(3'(s), v);
      chk(v === 24'h0, "R1 reset regs", {8'd0, v}, 0);
    end
    chk(out_valid === 0 && inval === 0, "R1 reset outs", {30'd0, out_valid, inval}, 0);

    rd(3'd4, v);
    @(negedge clk);
    chk(out_valid === 0 && inval === 0, "R10 nothing", {30'd0, out_valid, inval}, 0);
    rd(3'd1, v);
    chk(v[23:16] === 8'h03, "R10 empty code", {8'd0, v}, 32'h030000);

    for (int nseg = 1; nseg <= 4; nseg++) begin
      for (int len = 0; len < DEPTH / nseg; len++) begin
        logic [15:0] d = 16'(nseg * 256 + len);
        wr(3'd0, d);
        wr(3'd1, 16'(16'h5000 + nseg + len));
        n_exp = 0;
        for (int s = 0; s < nseg; s++) begin
          last_ptr = 16'(16'h0100 * s + nseg);
          wr(3'd2, last_ptr);
          exp_tag[n_exp] = 1; exp_word[n_exp] = last_ptr; n_exp++;
          for (int k = 0; k < len; k++) begin
            logic [15:0] w = 16'(16'hA000 + s * 16 + k + len);
            wr(3'd3, w);
            exp_tag[n_exp] = 0; exp_word[n_exp] = w; n_exp++;
          end
        end
        rd(3'd1, v);
        chk(v[15:0] === 16'(16'h5000 + nseg + len), "R2 func", {16'd0, v[15:0]}, 32'(16'h5000 + nseg + len));
        exec_ok(d, 8'h00);
        drain(n_exp, 1 + (len % 3));
        rd(3'd2, v);
        chk(v[15:0] === last_ptr, "R2 ptr", {16'd0, v[15:0]}, {16'd0, last_ptr});
        chk(cmd_dest === d, "R2 cmd_dest", {16'd0, cmd_dest}, {16'd0, d});
      end
    end

    wr(3'd0, 16'h0777);
    n_exp = 0;
    for (int k = 0; k < DEPTH + 2; k++) begin
      wr(3'd3, 16'(16'hC000 + k));
      if (k < DEPTH) begin exp_tag[n_exp] = 0; exp_word[n_exp] = 16'(16'hC000 + k); n_exp++; end
    end
    wr(3'd2, 16'h0ABC);
    rd(3'd2, v);
    chk(v === 24'h010ABC, "R8 overflow status and ptr", {8'd0, v}, 32'h010ABC);
    exec_ok(16'h0777, 8'h01);
    drain(n_exp, 2);

    wr(3'd0, 16'h0333);
    wr(3'd3, 16'h1111);
    wr(3'd3, 16'h2222);
    n_exp = 2;
    exp_tag[0] = 0; exp_word[0] = 16'h1111; exp_tag[1] = 0; exp_word[1] = 16'h2222;
    exec_ok(16'h0333, 8'h00);
    wr(3'd0, 16'h0999);
    wr(3'd3, 16'h9999);
    rd(3'd0, v);
    chk(v === 24'h020333, "R9 busy write", {8'd0, v}, 32'h020333);
    rd(3'd4, v);
    chk(inval === 1'b0, "R9 busy exec", {31'd0, inval}, 0);
    drain(2, 1);

    wr(3'd3, 16'h4444);
    rd(3'd0, v);
    chk(v[23:16] === 8'h02, "R3 status kept", {8'd0, v}, 32'h020333);
    n_exp = 1; exp_tag[0] = 0; exp_word[0] = 16'h4444;
    exec_ok(16'h0333, 8'h00);
    drain(1, 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule